// File: doc/BRIEF.md
# Three-Weight Accumulator Test Pattern Generator

This block is a test-per-clock pattern source built around a plain accumulator. An n-bit pattern register feeds back into one input of an adder. A second register supplies the value added on each clock, and the pattern register's contents drive the inputs of the circuit under test. With no bit pinned, the pattern register adds the loaded seed on every rising edge. The bits that change then follow a pseudo-random sequence whose character depends on the seed.

Two per-bit control vectors assign a weight to each output bit. A bit pinned high carries weight 1 and reads 1 on every pattern. A bit pinned low carries weight 0 and reads 0. A bit with neither control raised carries weight 0.5 and keeps accumulating. When a bit is pinned, the addend register is forced to the complement of the pinned value at the same position. That stage then passes its carry in straight to its carry out, so carries from the random bits below reach the random bits above. The adder is not modified. It can be a ripple chain of full-adder cells or a behavioural adder, chosen by a parameter.

Top module: `tpw_gen`

## Requirements
- R1: While `rst_n` is low at a rising edge, both registers clear to zero, so `pattern` reads 0 after that edge regardless of the other inputs.
- R2: With no bit pinned, each rising edge loads the pattern register with the previous pattern plus the previous addend, modulo 2^WIDTH.
- R3: For an unpinned bit, the addend register takes that bit of `seed_in` on every rising edge, so a seed change affects the pattern one edge after it is loaded.
- R4: A bit whose `pin_hi` is 1 and whose `pin_lo` is 0 reads 1 on `pattern` after every rising edge at which those values are present.
- R5: A bit whose `pin_lo` is 1 reads 0 on `pattern` after every rising edge at which that value is present.
- R6: If `pin_hi` and `pin_lo` are both 1 on the same bit, clearing wins, and the bit reads 0.
- R7: A pinned bit loads the addend register with the complement of its pinned value. Once pinned, the stage passes its carry in to its carry out unchanged, so the unpinned bits count as one contiguous accumulator that skips the pinned positions.
- R8: The carry out of the most significant bit is dropped, and the pattern wraps to the low end.
- R9: A new pattern appears on every clock. With seed 1 and no pins, the pattern after the k-th edge following reset is k-1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| seed_in | input | WIDTH | Constant addend for unpinned bits |
| pin_hi | input | WIDTH | Per-bit request to hold the output at 1 |
| pin_lo | input | WIDTH | Per-bit request to hold the output at 0; overrides pin_hi |
| pattern | output | WIDTH | Current test pattern for the circuit under test |

## Verification
A seed of 1 with no pins gives a plain count, which shows that the block steps once per clock. A seed of all ones shows the wrap at the top bit. Sessions that mix high pins, low pins and odd seeds are checked against a cycle model. Among them, a single low pin in the middle of a counting sequence shows whether a carry crosses the pinned stage (0,1,4,5,8 rather than 0,1,0,1). A seed change in the middle of a run and a bit with both pins raised separate the one-edge latency of the addend register and the priority of clearing over setting.

// File: rtl/tpw_pkg.sv
// Package: shared weight encoding for the three-weight pattern generator.
// Assumes: pins are resolved per bit; clearing has priority over setting.
package tpw_pkg;

    typedef enum logic [1:0] {
        WGT_RAND = 2'd0,
        WGT_ZERO = 2'd1,
        WGT_ONE  = 2'd2
    } weight_e;

    // Resolve one bit's pin requests into a weight.
    function automatic weight_e resolve_weight(input logic hi, input logic lo);
        if (lo)      return WGT_ZERO;
        else if (hi) return WGT_ONE;
        else         return WGT_RAND;
    endfunction

endpackage

// File: rtl/tpw_ctrl.sv
// Module: tpw_ctrl
// Turns per-bit pin requests into force lines for the pattern register (A)
// and the addend register (B). A's set line drives B's clear line, and A's
// clear line drives B's set line, so that a pinned stage sees complementary
// operands. Assumes: purely combinational; the registers apply the lines.
module tpw_ctrl
    import tpw_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] pin_hi,
    input  logic [WIDTH-1:0] pin_lo,
    output logic [WIDTH-1:0] a_set,
    output logic [WIDTH-1:0] a_clr,
    output logic [WIDTH-1:0] b_set,
    output logic [WIDTH-1:0] b_clr
);

    weight_e wgt [WIDTH];

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        // Decode the weight of bit i and cross-couple the force lines.
        always_comb begin
            wgt[i]   = resolve_weight(pin_hi[i], pin_lo[i]);
            a_set[i] = (wgt[i] == WGT_ONE);
            a_clr[i] = (wgt[i] == WGT_ZERO);
            b_set[i] = a_clr[i];
            b_clr[i] = a_set[i];
        end
    end

endmodule

// File: rtl/tpw_adder.sv
// Module: tpw_adder
// Unmodified WIDTH-bit adder with no carry in. It exposes its internal carry
// chain so that pass-through at pinned stages can be observed. RIPPLE=1
// builds a chain of full-adder cells; RIPPLE=0 uses a behavioural add and
// recovers each stage carry from its operands and sum bit.
// Assumes: carry[WIDTH] is the discarded carry out of the top stage.
module tpw_adder #(
    parameter int WIDTH  = 8,
    parameter bit RIPPLE = 1'b1
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    output logic [WIDTH-1:0] sum,
    output logic [WIDTH:0]   carry
);

    if (RIPPLE) begin : g_ripple
        assign carry[0] = 1'b0;
        for (genvar i = 0; i < WIDTH; i++) begin : g_fa
            // Full adder cell for stage i.
            always_comb begin
                sum[i]     = op_a[i] ^ op_b[i] ^ carry[i];
                carry[i+1] = (op_a[i] & op_b[i]) | ((op_a[i] ^ op_b[i]) & carry[i]);
            end
        end
    end else begin : g_behav
        logic [WIDTH:0] wide;
        // Behavioural add with the top carry kept.
        always_comb wide = {1'b0, op_a} + {1'b0, op_b};
        assign sum        = wide[WIDTH-1:0];
        assign carry[WIDTH] = wide[WIDTH];
        for (genvar i = 0; i < WIDTH; i++) begin : g_cin
            // Carry into stage i recovered from its operands and sum bit.
            always_comb carry[i] = op_a[i] ^ op_b[i] ^ wide[i];
        end
    end

endmodule

// File: rtl/tpw_regs.sv
// Module: tpw_regs
// Pattern register A and addend register B, one flop pair per bit, with
// force lines. Clear beats set on both registers. Assumes: force lines
// come from tpw_ctrl and are never both set on a bit of A.
module tpw_regs #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] seed,
    input  logic [WIDTH-1:0] sum,
    input  logic [WIDTH-1:0] a_set,
    input  logic [WIDTH-1:0] a_clr,
    input  logic [WIDTH-1:0] b_set,
    input  logic [WIDTH-1:0] b_clr,
    output logic [WIDTH-1:0] a_q,
    output logic [WIDTH-1:0] b_q
);

    for (genvar i = 0; i < WIDTH; i++) begin : g_cell
        // Pattern flop: forced value or accumulated sum bit.
        always_ff @(posedge clk) begin
            if (!rst_n)        a_q[i] <= 1'b0;
            else if (a_clr[i]) a_q[i] <= 1'b0;
            else if (a_set[i]) a_q[i] <= 1'b1;
            else               a_q[i] <= sum[i];
        end

        // Addend flop: forced complement or seed bit.
        always_ff @(posedge clk) begin
            if (!rst_n)        b_q[i] <= 1'b0;
            else if (b_clr[i]) b_q[i] <= 1'b0;
            else if (b_set[i]) b_q[i] <= 1'b1;
            else               b_q[i] <= seed[i];
        end
    end

    // R4
    pin_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (a_set != '0) |=> ((a_q & $past(a_set)) == $past(a_set)));

    // R5
    pin_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (a_clr != '0) |=> ((a_q & $past(a_clr)) == '0));

    // R7
    pin_compl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((a_set | a_clr) != '0) |=> (((a_q ^ b_q) & $past(a_set | a_clr)) == $past(a_set | a_clr)));

endmodule

// File: rtl/tpw_gen.sv
// Module: tpw_gen (top)
// Three-weight accumulator pattern generator: one pattern per clock. Pinned
// bits hold 0 or 1, and unpinned bits accumulate the seed. Assumes: rst_n is
// synchronous and active low, and the pin inputs are stable around the edge.
module tpw_gen #(
    parameter int WIDTH  = 8,
    parameter bit RIPPLE = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] seed_in,
    input  logic [WIDTH-1:0] pin_hi,
    input  logic [WIDTH-1:0] pin_lo,
    output logic [WIDTH-1:0] pattern
);

    logic [WIDTH-1:0] a_set, a_clr, b_set, b_clr;
    logic [WIDTH-1:0] a_q, b_q, sum;
    logic [WIDTH:0]   carry;

    tpw_ctrl #(.WIDTH(WIDTH)) u_ctrl (
        .pin_hi (pin_hi),
        .pin_lo (pin_lo),
        .a_set  (a_set),
        .a_clr  (a_clr),
        .b_set  (b_set),
        .b_clr  (b_clr)
    );

    tpw_adder #(.WIDTH(WIDTH), .RIPPLE(RIPPLE)) u_add (
        .op_a  (a_q),
        .op_b  (b_q),
        .sum   (sum),
        .carry (carry)
    );

    tpw_regs #(.WIDTH(WIDTH)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .seed  (seed_in),
        .sum   (sum),
        .a_set (a_set),
        .a_clr (a_clr),
        .b_set (b_set),
        .b_clr (b_clr),
        .a_q   (a_q),
        .b_q   (b_q)
    );

    assign pattern = a_q;

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (pattern == '0));

    // R2
    accum_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_hi | pin_lo) == '0) |=> (pattern == $past(a_q + b_q)));

    // R6
    clr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_hi & pin_lo) != '0) |=> ((pattern & $past(pin_hi & pin_lo)) == '0));

    for (genvar i = 0; i < WIDTH; i++) begin : g_pass
        // R7
        carry_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (a_q[i] ^ b_q[i]) |-> (carry[i+1] == carry[i]));
    end

    // R8
    wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (((pin_hi | pin_lo) == '0) && carry[WIDTH]) |=> (pattern < $past(a_q)));

endmodule

// File: tb/tb_tpw_gen.sv
module tb_tpw_gen;

    localparam int W      = 8;
    localparam int PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] seed_in = '0;
    logic [W-1:0] pin_hi = '0;
    logic [W-1:0] pin_lo = '0;
    logic [W-1:0] pattern;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic [W-1:0] m_a = '0;
    logic [W-1:0] m_b = '0;

    typedef struct packed {
        logic [W-1:0] seed;
        logic [W-1:0] hi;
        logic [W-1:0] lo;
        logic [7:0]   cycles;
    } vec_t;

    localparam int NVEC = 6;
    localparam vec_t VEC [NVEC] = '{
        '{8'h35, 8'h00, 8'h00, 8'd12},
        '{8'h35, 8'h81, 8'h00, 8'd10},
        '{8'h0B, 8'h00, 8'h24, 8'd10},
        '{8'h57, 8'h10, 8'h42, 8'd12},
        '{8'hC3, 8'h0F, 8'h0F, 8'd6},
        '{8'h01, 8'h00, 8'h00, 8'd8}
    };

    tpw_gen #(.WIDTH(W), .RIPPLE(1'b1)) dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .seed_in (seed_in),
        .pin_hi  (pin_hi),
        .pin_lo  (pin_lo),
        .pattern (pattern)
    );

    always #(PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: pattern=%h expected=%h", tag, got, exp);
        end
    endtask

    // Advance one edge, updating the cycle model from the requirements.
    task automatic tick();
        logic [W-1:0] s;
        logic [W-1:0] na, nb;
        @(posedge clk);
        s = m_a + m_b;
        for (int i = 0; i < W; i++) begin
            if (!rst_n)         begin na[i] = 1'b0; nb[i] = 1'b0; end
            else if (pin_lo[i]) begin na[i] = 1'b0; nb[i] = 1'b1; end
            else if (pin_hi[i]) begin na[i] = 1'b1; nb[i] = 1'b0; end
            else                begin na[i] = s[i]; nb[i] = seed_in[i]; end
        end
        m_a = na;
        m_b = nb;
        #(PERIOD/4);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        tick();
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        #(PERIOD * 50000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run did not finish");
        finish_run();
    end

    initial begin
        logic [W-1:0] exp_seq [5];

        // R1: reset with pins and seed active still clears.
        seed_in = 8'hFF; pin_hi = 8'hFF; pin_lo = 8'h00;
        do_reset();
        check("R1 reset clears", pattern, 8'h00);
        pin_hi = 8'h00;

        // Table walk against the cycle model.
        for (int v = 0; v < NVEC; v++) begin
            do_reset();
            seed_in = VEC[v].seed; pin_hi = VEC[v].hi; pin_lo = VEC[v].lo;
            for (int c = 0; c < int'(VEC[v].cycles); c++) begin
                tick();
                if ((VEC[v].hi | VEC[v].lo) == '0)
                    check("R2 accumulate", pattern, m_a);
                else
                    check("R7 pinned session", pattern, m_a);
                @(negedge clk);
            end
        end

        // R9: seed 1 counts 0,1,2,... one step per edge.
        do_reset();
        seed_in = 8'h01; pin_hi = '0; pin_lo = '0;
        for (int k = 1; k <= 6; k++) begin
            tick();
            check("R9 one per clock", pattern, W'(k - 1));
            @(negedge clk);
        end

        // R3: a seed change reaches the pattern one edge later (pattern now 5).
        seed_in = 8'h10;
        tick(); check("R3 old addend", pattern, 8'h06);
        @(negedge clk);
        tick(); check("R3 new addend", pattern, 8'h16);

        // R8: all-ones seed wraps: 00, FF, FE.
        do_reset();
        seed_in = 8'hFF;
        tick(); check("R8 first", pattern, 8'h00);
        @(negedge clk);
        tick(); check("R8 second", pattern, 8'hFF);
        @(negedge clk);
        tick(); check("R8 wrap", pattern, 8'hFE);

        // R7: low pin on bit 1 with seed 1: carry skips it -> 00,01,04,05,08.
        do_reset();
        seed_in = 8'h01; pin_lo = 8'h02;
        exp_seq = '{8'h00, 8'h01, 8'h04, 8'h05, 8'h08};
        for (int k = 0; k < 5; k++) begin
            tick();
            check("R7 carry pass", pattern, exp_seq[k]);
            @(negedge clk);
        end

        // R4: high pin on bit 7 holds while the rest accumulate.
        pin_lo = '0; pin_hi = 8'h80; seed_in = 8'h3F;
        for (int k = 0; k < 4; k++) begin
            tick();
            check("R4 pinned one", pattern & 8'h80, 8'h80);
            @(negedge clk);
        end

        // R5: low pin on bits 0 and 4 holds 0.
        pin_hi = '0; pin_lo = 8'h11; seed_in = 8'hFF;
        for (int k = 0; k < 4; k++) begin
            tick();
            check("R5 pinned zero", pattern & 8'h11, 8'h00);
            @(negedge clk);
        end

        // R6: both pins on bits 2 and 3; clearing wins.
        pin_hi = 8'h0C; pin_lo = 8'h0C; seed_in = 8'hFF;
        for (int k = 0; k < 3; k++) begin
            tick();
            check("R6 clear wins", pattern & 8'h0C, 8'h00);
            @(negedge clk);
        end

        finish_run();
    end

endmodule